// File: doc/BRIEF.md
# Byte-Level I2C Host Register Front-End

This block is the register-facing half of an I2C host controller. Software talks to it through five 8-bit registers: own address, clock divider, control, status and data. The block turns those accesses into byte-level commands for a separate bus engine: start with address and direction, send a byte, receive a byte, and end the transfer. Bit timing, clock division, arbitration and target-mode operation all belong to that engine or are not provided. Here the work is command sequencing, status-flag upkeep, soft reset and the level interrupt.

Each bus transaction is triggered by a register access. The first data-register write after the no-address state becomes the address phase. Later writes send payload bytes, and data-register reads fetch bytes. A register access that needs the bus is held (`req_ready` stays low) until the bus engine answers. Each access therefore finishes with its bus effects already reflected in the registers.

Top module: `i2c_host_regs`

## Requirements
- R1: After reset every register reads 0x00, `irq` is 0, and no command is issued.
- R2: Writes keep only writable bits: own address mask 0xFE, divider mask 0x3F, control mask 0xFC. Offsets are 0 own address, 1 divider, 2 control, 3 status, 4 data. A read from offsets 5 to 7 returns 0x00, and a write to them changes nothing.
- R3: A control write with bit 7 (enable) at 0, while enable is currently 1, is a soft reset. Divider, control, status and the data register return to 0 and `irq` drops. The own-address register keeps its value. If an address was latched, one end command (op 3) is issued.
- R4: A normal control write copies bit 5 (host mode) into status bit 5 (bus busy). If host mode is written as 0 while an address is latched, one end command is issued and the controller returns to the no-address state.
- R5: Control bit 2 (repeated start) written as 1 while an address is latched and host mode stays 1 issues one end command, returns to the no-address state, and bit 2 reads back 0. With no address latched, the bit is stored and reads back 1.
- R6: In host mode with enable set and no address latched, a data write issues a start command (op 0) carrying the written byte (bits 7:1 target, bit 0 direction). On NACK, status bit 0 becomes 1 and no address is latched. On ACK, status bit 0 becomes 0, the address is latched and the interrupt is raised.
- R7: With an address latched, a data write issues a send command (op 1) carrying the byte. On ACK, status bit 0 clears and the interrupt is raised. On NACK, status bit 0 sets, an end command follows, and the next data write is again an address phase.
- R8: In host mode, a data read with an address latched and control bit 4 (transmit) at 0 issues a receive command (op 2) and returns the received byte, raising the interrupt. A NACK response yields 0xFF. With no address latched, or with transmit set, the read returns 0xFF without any command. Outside host mode the read returns the stored byte.
- R9: Raising the interrupt sets status bit 1 and `irq` only when control bits 7 (enable) and 6 (interrupt enable) are both 1.
- R10: A status write clears bit 1 (and `irq`) or bit 4 only where the written bit is 0. Writing 1 leaves them unchanged. No other status bit is writable.
- R11: Data writes while enable is 0 issue no command and change no register.
- R12: A bus command holds its op and byte until accepted. `req_ready` pulses for exactly one cycle per access, and only after the bus response has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Register access request, held until `req_ready` |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Register offset |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read data, valid with `req_ready` |
| irq | output | 1 | Level interrupt, equal to status bit 1 |
| bus_cmd_valid | output | 1 | Bus command offered |
| bus_cmd_ready | input | 1 | Bus engine accepts the command |
| bus_cmd_op | output | 2 | 0 start, 1 send, 2 receive, 3 end |
| bus_cmd_byte | output | 8 | Address byte or payload (0 for receive and end) |
| bus_rsp_valid | input | 1 | Response for start, send or receive |
| bus_rsp_nack | input | 1 | Target did not acknowledge or receive failed |
| bus_rsp_data | input | 8 | Received byte |

## Verification
The hardest paths to reach are those where one access produces two bus commands, or where an end command depends on a latched address. Examples are a data byte refused mid-transfer, a repeated start with and without an address, and a soft reset during a transfer. The bench reaches these with a bus model whose NACK decision, received byte and response delay are set before each access. Directed sequences walk each path explicitly. A long random mix of control, data and status accesses, with NACKs injected about a quarter of the time, then drives the controller through arbitrary orderings. A bench-side register model predicts every read value, the interrupt level and the exact command stream.

// File: rtl/i2cm_pkg.sv
// Shared constants and types for the I2C host register front-end.
// Assumes 8-bit registers; bit positions below are decoded by software.
package i2cm_pkg;
    localparam int REG_W = 8;

    // control register bit positions
    localparam int C_EN   = 7;
    localparam int C_IEN  = 6;
    localparam int C_HOST = 5;
    localparam int C_TX   = 4;
    localparam int C_RSTA = 2;

    // status register bit positions
    localparam int S_BUSY = 5;
    localparam int S_ALOST = 4;
    localparam int S_IFLAG = 1;
    localparam int S_NACK = 0;

    // writable masks
    localparam logic [REG_W-1:0] OWN_MASK  = 8'hFE;
    localparam logic [REG_W-1:0] DIV_MASK  = 8'h3F;
    localparam logic [REG_W-1:0] CTRL_MASK = 8'hFC;

    // register offsets
    localparam int OFF_OWN  = 0;
    localparam int OFF_DIV  = 1;
    localparam int OFF_CTRL = 2;
    localparam int OFF_STAT = 3;
    localparam int OFF_DATA = 4;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_SEND  = 2'd1,
        OP_RECV  = 2'd2,
        OP_STOP  = 2'd3
    } bus_op_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_CMD,
        SQ_RSP
    } seq_state_e;

    typedef enum logic [1:0] {
        RF_IDLE,
        RF_WAIT,
        RF_DONE
    } rf_state_e;

    typedef enum logic [1:0] {
        PD_ADDR,
        PD_SEND,
        PD_RECV,
        PD_STOP
    } pend_e;
endpackage

// File: rtl/i2cm_seq.sv
// Bus command sequencer: takes one launch pulse, offers the command with a
// valid/ready handshake, then waits for the response (none for an end
// command) and reports it with a one-cycle done pulse.
// Assumes a launch only arrives while the sequencer is idle.
module i2cm_seq
    import i2cm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  bus_op_e          go_op,
    input  logic [REG_W-1:0] go_byte,
    output logic             done,
    output logic             res_nack,
    output logic [REG_W-1:0] res_data,
    output logic             bus_cmd_valid,
    input  logic             bus_cmd_ready,
    output logic [1:0]       bus_cmd_op,
    output logic [REG_W-1:0] bus_cmd_byte,
    input  logic             bus_rsp_valid,
    input  logic             bus_rsp_nack,
    input  logic [REG_W-1:0] bus_rsp_data
);
    seq_state_e       state_q;
    bus_op_e          op_q;
    logic [REG_W-1:0] byte_q;

    // command outputs come straight from held state
    assign bus_cmd_valid = (state_q == SQ_CMD);
    assign bus_cmd_op    = op_q;
    assign bus_cmd_byte  = byte_q;

    // handshake state machine and response capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SQ_IDLE;
            op_q     <= OP_START;
            byte_q   <= '0;
            done     <= 1'b0;
            res_nack <= 1'b0;
            res_data <= '0;
        end else begin
            done <= 1'b0;
            case (state_q)
                SQ_IDLE: begin
                    if (go) begin
                        op_q    <= go_op;
                        byte_q  <= go_byte;
                        state_q <= SQ_CMD;
                    end
                end
                SQ_CMD: begin
                    if (bus_cmd_ready) begin
                        if (op_q == OP_STOP) begin
                            done     <= 1'b1;
                            res_nack <= 1'b0;
                            state_q  <= SQ_IDLE;
                        end else begin
                            state_q <= SQ_RSP;
                        end
                    end
                end
                SQ_RSP: begin
                    if (bus_rsp_valid) begin
                        done     <= 1'b1;
                        res_nack <= bus_rsp_nack;
                        res_data <= bus_rsp_data;
                        state_q  <= SQ_IDLE;
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    // R12: an offered command keeps its op and byte until accepted
    p_cmd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd_valid && !bus_cmd_ready) |=>
            (bus_cmd_valid && $stable(bus_cmd_op) && $stable(bus_cmd_byte)));

    // R12: launches never overlap a command in flight
    p_go_when_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> (state_q == SQ_IDLE));
endmodule

// File: rtl/i2cm_regfile.sv
// Register file and access decoder: holds the five registers, applies
// masks, soft reset and flag rules, and hands bus work to the sequencer.
// Assumes the requester holds its access until the one-cycle ready pulse.
module i2cm_regfile
    import i2cm_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [REG_W-1:0]  req_wdata,
    output logic              req_ready,
    output logic [REG_W-1:0]  rsp_rdata,
    output logic              irq,
    output logic              go,
    output bus_op_e           go_op,
    output logic [REG_W-1:0]  go_byte,
    input  logic              seq_done,
    input  logic              seq_nack,
    input  logic [REG_W-1:0]  seq_data
);
    localparam logic [ADDR_W-1:0] A_OWN  = ADDR_W'(OFF_OWN);
    localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(OFF_DIV);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFF_DATA);
    localparam logic [REG_W-1:0]  ALL1   = {REG_W{1'b1}};

    rf_state_e        state_q;
    pend_e            pend_q;
    logic [REG_W-1:0] own_q, div_q, ctrl_q, stat_q, rdat_q;
    logic             lat_q;
    logic             can_irq;

    // decoded effects of a control write
    logic             cw_soft, cw_end_host, cw_end_rsta, cw_stop;
    logic [REG_W-1:0] cw_ctrl;

    assign req_ready = (state_q == RF_DONE);
    assign irq       = stat_q[S_IFLAG];
    assign can_irq   = ctrl_q[C_EN] && ctrl_q[C_IEN];

    // control-write decode: soft reset, leaving host mode, repeated start
    always_comb begin
        cw_ctrl     = req_wdata & CTRL_MASK;
        cw_soft     = ctrl_q[C_EN] && !req_wdata[C_EN];
        cw_end_host = !cw_ctrl[C_HOST] && lat_q;
        cw_end_rsta = cw_ctrl[C_HOST] && cw_ctrl[C_RSTA] && lat_q;
        cw_stop     = cw_soft ? lat_q : (cw_end_host || cw_end_rsta);
    end

    // access handling, register updates and bus launches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= RF_IDLE;
            pend_q    <= PD_STOP;
            own_q     <= '0;
            div_q     <= '0;
            ctrl_q    <= '0;
            stat_q    <= '0;
            rdat_q    <= '0;
            lat_q     <= 1'b0;
            rsp_rdata <= '0;
            go        <= 1'b0;
            go_op     <= OP_STOP;
            go_byte   <= '0;
        end else begin
            go <= 1'b0;
            case (state_q)
                RF_IDLE: begin
                    if (req_valid) begin
                        rsp_rdata <= '0;
                        state_q   <= RF_DONE;
                        if (req_write) begin
                            case (req_addr)
                                A_OWN: own_q <= req_wdata & OWN_MASK;
                                A_DIV: div_q <= req_wdata & DIV_MASK;
                                A_CTRL: begin
                                    if (cw_soft) begin
                                        div_q  <= '0;
                                        ctrl_q <= '0;
                                        stat_q <= '0;
                                        rdat_q <= '0;
                                    end else begin
                                        ctrl_q <= cw_end_rsta ?
                                            (cw_ctrl & ~(REG_W'(1) << C_RSTA)) : cw_ctrl;
                                        stat_q[S_BUSY] <= cw_ctrl[C_HOST];
                                    end
                                    if (cw_stop) begin
                                        lat_q   <= 1'b0;
                                        go      <= 1'b1;
                                        go_op   <= OP_STOP;
                                        go_byte <= '0;
                                        pend_q  <= PD_STOP;
                                        state_q <= RF_WAIT;
                                    end
                                end
                                A_STAT: begin
                                    stat_q[S_IFLAG] <= stat_q[S_IFLAG] & req_wdata[S_IFLAG];
                                    stat_q[S_ALOST] <= stat_q[S_ALOST] & req_wdata[S_ALOST];
                                end
                                A_DATA: begin
                                    if (ctrl_q[C_EN] && ctrl_q[C_HOST]) begin
                                        go      <= 1'b1;
                                        go_byte <= req_wdata;
                                        go_op   <= lat_q ? OP_SEND : OP_START;
                                        pend_q  <= lat_q ? PD_SEND : PD_ADDR;
                                        state_q <= RF_WAIT;
                                    end
                                end
                                default: ;
                            endcase
                        end else begin
                            case (req_addr)
                                A_OWN:  rsp_rdata <= own_q;
                                A_DIV:  rsp_rdata <= div_q;
                                A_CTRL: rsp_rdata <= ctrl_q;
                                A_STAT: rsp_rdata <= stat_q;
                                A_DATA: begin
                                    if (!ctrl_q[C_HOST]) begin
                                        rsp_rdata <= rdat_q;
                                    end else if (!lat_q || ctrl_q[C_TX]) begin
                                        rdat_q    <= ALL1;
                                        rsp_rdata <= ALL1;
                                    end else begin
                                        go      <= 1'b1;
                                        go_op   <= OP_RECV;
                                        go_byte <= '0;
                                        pend_q  <= PD_RECV;
                                        state_q <= RF_WAIT;
                                    end
                                end
                                default: ;
                            endcase
                        end
                    end
                end
                RF_WAIT: begin
                    if (seq_done) begin
                        state_q <= RF_DONE;
                        case (pend_q)
                            PD_ADDR: begin
                                stat_q[S_NACK] <= seq_nack;
                                if (!seq_nack) begin
                                    lat_q <= 1'b1;
                                    if (can_irq) stat_q[S_IFLAG] <= 1'b1;
                                end
                            end
                            PD_SEND: begin
                                stat_q[S_NACK] <= seq_nack;
                                if (seq_nack) begin
                                    lat_q   <= 1'b0;
                                    go      <= 1'b1;
                                    go_op   <= OP_STOP;
                                    go_byte <= '0;
                                    pend_q  <= PD_STOP;
                                    state_q <= RF_WAIT;
                                end else if (can_irq) begin
                                    stat_q[S_IFLAG] <= 1'b1;
                                end
                            end
                            PD_RECV: begin
                                rdat_q    <= seq_nack ? ALL1 : seq_data;
                                rsp_rdata <= seq_nack ? ALL1 : seq_data;
                                if (!seq_nack && can_irq) stat_q[S_IFLAG] <= 1'b1;
                            end
                            default: ;
                        endcase
                    end
                end
                RF_DONE: state_q <= RF_IDLE;
                default: state_q <= RF_IDLE;
            endcase
        end
    end

    // R12: completion is a single-cycle pulse
    p_ready_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready);

    // R4: bus-busy always mirrors the stored host-mode bit
    p_busy_mirror_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stat_q[S_BUSY] == ctrl_q[C_HOST]);

    // R9: the interrupt flag only rises with both enables set
    p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q[S_IFLAG]) |-> (ctrl_q[C_EN] && ctrl_q[C_IEN]));

    // R11: transfer commands are only launched when enabled in host mode
    p_no_xfer_disabled_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (go && go_op != OP_STOP) |-> (ctrl_q[C_EN] && ctrl_q[C_HOST]));
endmodule

// File: rtl/i2c_host_regs.sv
// Top of the I2C host register front-end: register port on one side,
// byte-level bus command/response port on the other, one level interrupt.
// Assumes a bus engine that answers every start, send and receive command.
module i2c_host_regs
    import i2cm_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_wdata,
    output logic              req_ready,
    output logic [7:0]        rsp_rdata,
    output logic              irq,
    output logic              bus_cmd_valid,
    input  logic              bus_cmd_ready,
    output logic [1:0]        bus_cmd_op,
    output logic [7:0]        bus_cmd_byte,
    input  logic              bus_rsp_valid,
    input  logic              bus_rsp_nack,
    input  logic [7:0]        bus_rsp_data
);
    logic             go, seq_done, seq_nack;
    bus_op_e          go_op;
    logic [REG_W-1:0] go_byte, seq_data;

    i2cm_regfile #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_ready (req_ready),
        .rsp_rdata (rsp_rdata),
        .irq       (irq),
        .go        (go),
        .go_op     (go_op),
        .go_byte   (go_byte),
        .seq_done  (seq_done),
        .seq_nack  (seq_nack),
        .seq_data  (seq_data)
    );

    i2cm_seq u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .go            (go),
        .go_op         (go_op),
        .go_byte       (go_byte),
        .done          (seq_done),
        .res_nack      (seq_nack),
        .res_data      (seq_data),
        .bus_cmd_valid (bus_cmd_valid),
        .bus_cmd_ready (bus_cmd_ready),
        .bus_cmd_op    (bus_cmd_op),
        .bus_cmd_byte  (bus_cmd_byte),
        .bus_rsp_valid (bus_rsp_valid),
        .bus_rsp_nack  (bus_rsp_nack),
        .bus_rsp_data  (bus_rsp_data)
    );
endmodule

// File: tb/i2c_host_regs_test.sv
`timescale 1ns/1ps
module i2c_host_regs_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_write = 1'b0;
    logic [2:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic       req_ready, irq, bus_cmd_valid;
    logic [7:0] rsp_rdata, bus_cmd_byte;
    logic [1:0] bus_cmd_op;
    logic       bus_cmd_ready = 1'b0, bus_rsp_valid = 1'b0, bus_rsp_nack = 1'b0;
    logic [7:0] bus_rsp_data = '0;

    always #2.5 clk = ~clk;

    i2c_host_regs uut (.*);

    int total = 0, bad = 0;
    // bus knobs
    bit nack_next = 0; logic [7:0] rx_next = 8'h00; int rsp_delay = 1;
    // command logs
    logic [1:0] a_op [0:2047]; logic [7:0] a_byte [0:2047]; int n_act = 0;
    logic [1:0] e_op [0:2047]; logic [7:0] e_byte [0:2047]; int n_exp = 0;
    int n_seen = 0;
    // register model
    logic [7:0] m_own = 0, m_div = 0, m_ctrl = 0, m_stat = 0, m_data = 0;
    bit m_lat = 0;

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // bus engine model
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && bus_cmd_valid) begin
                logic [1:0] op;
                repeat ($urandom % 2) @(negedge clk);
                bus_cmd_ready = 1'b1;
                a_op[n_act] = bus_cmd_op; a_byte[n_act] = bus_cmd_byte; n_act++;
                op = bus_cmd_op;
                @(negedge clk);
                bus_cmd_ready = 1'b0;
                if (op != 2'd3) begin
                    repeat (rsp_delay) @(negedge clk);
                    bus_rsp_valid = 1'b1; bus_rsp_nack = nack_next; bus_rsp_data = rx_next;
                    @(negedge clk);
                    bus_rsp_valid = 1'b0;
                end
            end
        end
    end

    task automatic exp_cmd(logic [1:0] op, logic [7:0] b);
        e_op[n_exp] = op; e_byte[n_exp] = b; n_exp++;
    endtask

    task automatic m_raise();
        if (m_ctrl[7] && m_ctrl[6]) m_stat[1] = 1'b1;
    endtask

    task automatic m_write(logic [2:0] a, logic [7:0] d);
        case (a)
            3'd0: m_own = d & 8'hFE;
            3'd1: m_div = d & 8'h3F;
            3'd2: begin
                if (m_ctrl[7] && !d[7]) begin
                    if (m_lat) exp_cmd(3, 0);
                    m_div = 0; m_ctrl = 0; m_stat = 0; m_data = 0; m_lat = 0;
                end else begin
                    m_ctrl = d & 8'hFC;
                    m_stat[5] = m_ctrl[5];
                    if (!m_ctrl[5] && m_lat) begin exp_cmd(3, 0); m_lat = 0; end
                    if (m_ctrl[2] && m_lat) begin exp_cmd(3, 0); m_lat = 0; m_ctrl[2] = 0; end
                end
            end
            3'd3: begin m_stat[1] = m_stat[1] & d[1]; m_stat[4] = m_stat[4] & d[4]; end
            3'd4: begin
                if (m_ctrl[7] && m_ctrl[5]) begin
                    if (!m_lat) begin
                        exp_cmd(0, d);
                        if (nack_next) m_stat[0] = 1;
                        else begin m_stat[0] = 0; m_lat = 1; m_raise(); end
                    end else begin
                        exp_cmd(1, d);
                        if (nack_next) begin m_stat[0] = 1; m_lat = 0; exp_cmd(3, 0); end
                        else begin m_stat[0] = 0; m_raise(); end
                    end
                end
            end
            default: ;
        endcase
    endtask

    task automatic m_read(logic [2:0] a, output logic [7:0] v);
        case (a)
            3'd0: v = m_own;
            3'd1: v = m_div;
            3'd2: v = m_ctrl;
            3'd3: v = m_stat;
            3'd4: begin
                if (m_ctrl[5]) begin
                    if (!m_lat || m_ctrl[4]) m_data = 8'hFF;
                    else begin
                        exp_cmd(2, 0);
                        m_data = nack_next ? 8'hFF : rx_next;
                        if (!nack_next) m_raise();
                    end
                end
                v = m_data;
            end
            default: v = 8'h00;
        endcase
    endtask

    task automatic access(bit wr, logic [2:0] a, logic [7:0] d,
                          output logic [7:0] q, output int cyc);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; cyc = 0;
        do begin @(negedge clk); cyc++; end while (!req_ready);
        q = rsp_rdata;
        req_valid = 1'b0;
    endtask

    task automatic check_cmds(string tag);
        bit ok = 1;
        check({tag, " cmd count"}, n_act, n_exp);
        if (n_act == n_exp) begin
            for (int i = n_seen; i < n_act; i++)
                if (a_op[i] != e_op[i] || a_byte[i] != e_byte[i]) begin
                    ok = 0;
                    check({tag, " cmd"}, {a_op[i], a_byte[i]}, {e_op[i], e_byte[i]});
                end
            if (ok) check({tag, " cmd content"}, 1, 1);
        end
        n_seen = n_act;
        check({tag, " irq"}, irq, m_stat[1]);
    endtask

    task automatic do_wr(string tag, logic [2:0] a, logic [7:0] d);
        logic [7:0] q; int cyc;
        m_write(a, d);
        access(1'b1, a, d, q, cyc);
        check_cmds(tag);
    endtask

    task automatic do_rd(string tag, logic [2:0] a);
        logic [7:0] q, e; int cyc;
        m_read(a, e);
        access(1'b0, a, 8'h00, q, cyc);
        check({tag, " rdata"}, q, e);
        check_cmds(tag);
    endtask

    task automatic rd_all(string tag);
        for (int i = 0; i < 5; i++) do_rd(tag, 3'(i));
    endtask

    // watchdog
    initial begin
        #750000;
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 irq after reset", irq, 0);
        check("R1 no command", bus_cmd_valid, 0);
        rd_all("R1 reset read");
        // R2 masks and unmapped offsets
        do_wr("R2 own", 0, 8'hFF); do_wr("R2 div", 1, 8'hFF); do_wr("R2 ctrl", 2, 8'h0F);
        do_wr("R2 unmapped wr", 6, 8'hFF);
        rd_all("R2 masked read");
        do_rd("R2 unmapped rd5", 5); do_rd("R2 unmapped rd7", 7);
        // R11 disabled host-mode data write
        do_wr("R4 host busy", 2, 8'h20);
        do_wr("R11 disabled data", 4, 8'hA4);
        do_rd("R11 status", 3);
        // R9 no interrupt without irq enable; R6 address ACK
        do_wr("R9 en no ien", 2, 8'hA0);
        do_wr("R6 addr ack", 4, 8'h50);
        do_rd("R9 stat no flag", 3);
        // R7 send ACK raises flag once enabled
        do_wr("R9 ien on", 2, 8'hE0);
        do_wr("R7 send ack", 4, 8'h3C);
        do_rd("R9 flag set", 3);
        // R10 status clear rules
        do_wr("R10 write one", 3, 8'h12);
        do_rd("R10 kept", 3);
        do_wr("R10 write zero", 3, 8'h00);
        do_rd("R10 cleared", 3);
        // R7 send NACK then new address phase
        nack_next = 1; do_wr("R7 send nack", 4, 8'h77); nack_next = 0;
        do_rd("R7 nack status", 3);
        do_wr("R7 readdress", 4, 8'h51);
        // R8 receive cases
        do_wr("R8 tx on", 2, 8'hF0);
        do_rd("R8 tx read", 4);
        do_wr("R8 tx off", 2, 8'hE0);
        rx_next = 8'h5A; do_rd("R8 recv", 4);
        nack_next = 1; do_rd("R8 recv fail", 4); nack_next = 0;
        // R5 repeated start with and without latched address
        do_wr("R5 rsta latched", 2, 8'hE4); do_rd("R5 ctrl self clear", 2);
        do_wr("R5 rsta idle", 2, 8'hE4); do_rd("R5 ctrl kept", 2);
        do_wr("R5 restore", 2, 8'hE0);
        do_rd("R8 no addr read", 4);
        // R6 address NACK
        nack_next = 1; do_wr("R6 addr nack", 4, 8'hA1); nack_next = 0;
        do_rd("R6 nack status", 3);
        do_wr("R6 addr retry", 4, 8'hA1);
        // R4 leaving host mode ends the transfer
        do_wr("R4 host off", 2, 8'hC0); do_rd("R4 busy clear", 3);
        // R3 soft reset keeps own address
        do_wr("R3 own", 0, 8'h88); do_wr("R3 div", 1, 8'h15);
        do_wr("R3 host", 2, 8'hE0); do_wr("R3 addr", 4, 8'h20);
        do_wr("R3 soft reset", 2, 8'h00);
        rd_all("R3 after soft reset");
        // R12 access held until delayed response
        begin
            logic [7:0] q; int cyc;
            do_wr("R12 setup", 2, 8'hE0);
            rsp_delay = 6;
            m_write(4, 8'h42);
            access(1'b1, 4, 8'h42, q, cyc);
            check("R12 held cycles>=7", cyc >= 7, 1);
            @(negedge clk);
            check("R12 ready pulse", req_ready, 0);
            check_cmds("R12 cmds");
        end
        // random mix covering R1-style reads and all write paths
        for (int it = 0; it < 400; it++) begin
            logic [7:0] v;
            int sel;
            nack_next = ($urandom % 4 == 0);
            rx_next = 8'($urandom);
            rsp_delay = $urandom % 4;
            v = 8'($urandom);
            sel = $urandom % 10;
            if (sel < 2) begin
                if ($urandom % 5 != 0) v[7] = 1'b1;
                if ($urandom % 5 != 0) v[5] = 1'b1;
                do_wr("R4 random ctrl", 2, v);
            end else if (sel < 5) do_wr("R6 R7 random data wr", 4, v);
            else if (sel < 7) do_rd("R8 random data rd", 4);
            else if (sel < 8) do_wr("R10 random stat wr", 3, v);
            else do_rd("R2 random reg rd", 3'($urandom % 8));
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule